// File: doc/BRIEF.md
# Load/Store Alignment Exception Detector

This unit sits in a processor's load/store path after address generation and decides, for each memory access, whether the access must trap with an alignment exception. It does not simply test whether the address is a multiple of the access size. The decision depends on the kind of instruction, the byte-order mode, and which of two core variants is in use: a legacy variant and an enhanced variant. It also looks at whether the access straddles a 256 MB segment whose translation-type bit differs from that of the segment it starts in.

Each request comes with a strobe, a decoded access class, the effective address, the access size as a power of two, the little-endian mode flag, the variant select, and the translation-type bits of the segments holding the first and last byte. One clock later the unit presents a result-valid flag, an exception flag and a 3-bit cause code. When several rules fire together, the smallest nonzero cause code is reported.

Top module: `align_exc_unit`

## Requirements
- R1: For class 3 (load-reserve / store-conditional), an address that is not a multiple of the access size gives cause 1 on both variants. A size-aligned address gives cause 0.
- R2: For class 4 (string / multiple) with `le_mode` = 1, the cause is 2 on both variants. With `le_mode` = 0, no exception comes from this rule.
- R3: For class 0 (plain), a misaligned access that crosses no segment gives cause 0 on both variants, whatever the value of `le_mode`.
- R4: For class 5 (external-control word), the cause is 3 when `legacy_core` = 1 and 0 when `legacy_core` = 0.
- R5: The last byte is at address + 2^size − 1, computed modulo 2^32. The access crosses a segment when bits [31:28] differ between its first and last byte. With `legacy_core` = 1, a crossing with `tbit_first` ≠ `tbit_last` gives cause 4. The cause is 0 when the bits are equal, when there is no crossing, or when `legacy_core` = 0.
- R6: For class 2 (floating-point), a doubleword access (size 3) at a word-aligned address gives cause 0.
- R7: Class 1 (byte-reversed) follows the same rules as class 0.
- R8: For classes 6, 7 and 8 (SIMD scalar, SIMD vector element, SIMD vector element with doubleword rule), an address that is not a multiple of the element size gives cause 5.
- R9: For class 8, an address that is naturally aligned but not a multiple of 8 gives cause 6.
- R10: When several rules hold at once, the smallest code among them is reported. `exc_flag` is 1 exactly when `exc_cause` is nonzero.
- R11: A request with `req_valid` = 1 sets `out_valid` = 1 on the next clock, with its flag and cause. A cycle with `req_valid` = 0 gives `out_valid`, `exc_flag` and `exc_cause` all 0 on the next clock.
- R12: While `rst` is high, all outputs are 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request strobe |
| req_class | input | 4 | Access class code (0..8, see requirements) |
| req_addr | input | 32 | Effective address of first byte |
| req_size_lg | input | 3 | log2 of access size in bytes |
| le_mode | input | 1 | Little-endian mode active |
| legacy_core | input | 1 | 1 = legacy variant, 0 = enhanced variant |
| tbit_first | input | 1 | Translation-type bit of first byte's segment |
| tbit_last | input | 1 | Translation-type bit of last byte's segment |
| out_valid | output | 1 | Result valid, one cycle after strobe |
| exc_flag | output | 1 | Alignment exception required |
| exc_cause | output | 3 | Cause code 0..6 |

## Verification
The segment-crossing rule (cause 4) can fire in the same cycle as the string/multiple rule or the reservation rule. The bench provokes this on the legacy variant by placing a little-endian string access, or a misaligned reservation access, so that it straddles a 256 MB boundary with different translation-type bits. It judges the result by requiring the lower code, 2 or 1, and not 4. In the same way, a doubleword-rule SIMD access that is also misaligned for its element size must report 5, not 6.

// File: rtl/align_chk_pkg.sv
package align_chk_pkg;

    localparam int unsigned CAUSE_W = 3;
    localparam int unsigned NUM_RULES = 6;

    typedef enum logic [3:0] {
        CLS_PLAIN    = 4'd0,
        CLS_BYTEREV  = 4'd1,
        CLS_FPDBL    = 4'd2,
        CLS_RESERVE  = 4'd3,
        CLS_STRMULT  = 4'd4,
        CLS_EXTCTL   = 4'd5,
        CLS_SIMD_SCL = 4'd6,
        CLS_SIMD_VEC = 4'd7,
        CLS_SIMD_V64 = 4'd8
    } acc_class_e;

    typedef enum logic [CAUSE_W-1:0] {
        CAUSE_NONE  = 3'd0,
        CAUSE_RSV   = 3'd1,
        CAUSE_LESTR = 3'd2,
        CAUSE_EXT   = 3'd3,
        CAUSE_SEGX  = 3'd4,
        CAUSE_SNAT  = 3'd5,
        CAUSE_SDW   = 3'd6
    } cause_e;

    // true when the low address byte is not a multiple of 2^lg
    function automatic logic off_natural(input logic [7:0] lo, input logic [2:0] lg);
        logic [7:0] mask;
        mask = (8'd1 << lg) - 8'd1;
        return (lo & mask) != 8'd0;
    endfunction

endpackage

// File: rtl/align_seg_check.sv
module align_seg_check #(
    parameter int unsigned ADDR_W  = 32,
    parameter int unsigned LG_W    = 3,
    parameter int unsigned SEG_LSB = 28
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic [LG_W-1:0]   size_lg,
    output logic              seg_cross
);
    localparam logic [ADDR_W-1:0] ONE = {{(ADDR_W-1){1'b0}}, 1'b1};

    logic [ADDR_W-1:0] span;
    logic [ADDR_W-1:0] last_addr;

    always_comb begin
        span      = (ONE << size_lg) - ONE;
        last_addr = addr + span;
        seg_cross = addr[ADDR_W-1:SEG_LSB] != last_addr[ADDR_W-1:SEG_LSB];
    end

    // an access that wraps past the top of the address space has to be a crossing
    always_comb begin
        if (!$isunknown(addr) && !$isunknown(size_lg) && (last_addr < addr))
            assert_wrap_is_cross_R5: assert (seg_cross);
    end
endmodule

// File: rtl/align_rule_eval.sv
module align_rule_eval
    import align_chk_pkg::*;
#(
    parameter int unsigned LG_W = 3
) (
    input  acc_class_e            cls,
    input  logic [7:0]            addr_lo,
    input  logic [LG_W-1:0]       size_lg,
    input  logic                  le_mode,
    input  logic                  legacy_core,
    input  logic                  seg_cross,
    input  logic                  tbit_first,
    input  logic                  tbit_last,
    output logic [NUM_RULES-1:0]  hits
);
    logic mis_nat;
    logic is_simd;

    always_comb begin
        mis_nat = off_natural(addr_lo, 3'(size_lg));
        is_simd = (cls == CLS_SIMD_SCL) || (cls == CLS_SIMD_VEC) || (cls == CLS_SIMD_V64);
        // hits[k] corresponds to cause code k+1
        hits[0] = (cls == CLS_RESERVE) && mis_nat;
        hits[1] = (cls == CLS_STRMULT) && le_mode;
        hits[2] = (cls == CLS_EXTCTL) && legacy_core;
        hits[3] = legacy_core && seg_cross && (tbit_first != tbit_last);
        hits[4] = is_simd && mis_nat;
        hits[5] = (cls == CLS_SIMD_V64) && (addr_lo[2:0] != 3'd0);
    end

    // enhanced variant never raises the external-control or segment rules
    always_comb begin
        if (!$isunknown(legacy_core) && !legacy_core && !$isunknown(hits))
            assert_enh_quiet_R4: assert (!hits[2] && !hits[3]);
    end
endmodule

// File: rtl/align_cause_pick.sv
module align_cause_pick #(
    parameter int unsigned N  = 6,
    parameter int unsigned CW = 3
) (
    input  logic [N-1:0]  hits,
    output logic [CW-1:0] code,
    output logic          any
);
    logic [N-1:0] grant;

    generate
        for (genvar i = 0; i < N; i++) begin : g_grant
            localparam logic [N-1:0] BELOW = (N'(1) << i) - N'(1);
            assign grant[i] = hits[i] & ~|(hits & BELOW);
        end
    endgenerate

    always_comb begin
        code = '0;
        for (int i = 0; i < N; i++) begin
            if (grant[i]) code = code | CW'(i + 1);
        end
        any = |hits;
    end

    always_comb begin
        if (!$isunknown(hits)) begin
            assert_single_grant_R10: assert ($onehot0(grant));
            assert_any_has_grant_R10: assert (any == (grant != '0));
        end
    end
endmodule

// File: rtl/align_exc_unit.sv
module align_exc_unit
    import align_chk_pkg::*;
#(
    parameter int unsigned ADDR_W  = 32,
    parameter int unsigned LG_W    = 3,
    parameter int unsigned SEG_LSB = 28
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req_valid,
    input  logic [3:0]        req_class,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [LG_W-1:0]   req_size_lg,
    input  logic              le_mode,
    input  logic              legacy_core,
    input  logic              tbit_first,
    input  logic              tbit_last,
    output logic              out_valid,
    output logic              exc_flag,
    output logic [CAUSE_W-1:0] exc_cause
);
    acc_class_e           cls;
    logic                 seg_cross;
    logic [NUM_RULES-1:0] hits;
    logic [CAUSE_W-1:0]   pick_code;
    logic                 pick_any;

    assign cls = acc_class_e'(req_class);

    align_seg_check #(.ADDR_W(ADDR_W), .LG_W(LG_W), .SEG_LSB(SEG_LSB)) u_seg (
        .addr      (req_addr),
        .size_lg   (req_size_lg),
        .seg_cross (seg_cross)
    );

    align_rule_eval #(.LG_W(LG_W)) u_rules (
        .cls         (cls),
        .addr_lo     (req_addr[7:0]),
        .size_lg     (req_size_lg),
        .le_mode     (le_mode),
        .legacy_core (legacy_core),
        .seg_cross   (seg_cross),
        .tbit_first  (tbit_first),
        .tbit_last   (tbit_last),
        .hits        (hits)
    );

    align_cause_pick #(.N(NUM_RULES), .CW(CAUSE_W)) u_pick (
        .hits (hits),
        .code (pick_code),
        .any  (pick_any)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            out_valid <= 1'b0;
            exc_flag  <= 1'b0;
            exc_cause <= '0;
        end else begin
            out_valid <= req_valid;
            exc_flag  <= req_valid & pick_any;
            exc_cause <= req_valid ? pick_code : '0;
        end
    end

    assert_reset_clear_R12: assert property (@(posedge clk)
        rst |=> (!out_valid && !exc_flag && exc_cause == '0));

    assert_idle_clear_R11: assert property (@(posedge clk) disable iff (rst)
        !req_valid |=> (!out_valid && !exc_flag && exc_cause == '0));

    assert_strobe_valid_R11: assert property (@(posedge clk) disable iff (rst)
        req_valid |=> out_valid);

    assert_flag_matches_R10: assert property (@(posedge clk) disable iff (rst)
        exc_flag == (exc_cause != '0));

    assert_reserve_R1: assert property (@(posedge clk) disable iff (rst)
        (req_valid && cls == CLS_RESERVE && off_natural(req_addr[7:0], 3'(req_size_lg)))
        |=> exc_cause == CAUSE_RSV);

    assert_le_string_R2: assert property (@(posedge clk) disable iff (rst)
        (req_valid && cls == CLS_STRMULT && le_mode) |=> exc_cause == CAUSE_LESTR);

    assert_ext_enh_R4: assert property (@(posedge clk) disable iff (rst)
        (req_valid && cls == CLS_EXTCTL && !legacy_core) |=> exc_cause != CAUSE_EXT);

    assert_seg_cross_R5: assert property (@(posedge clk) disable iff (rst)
        (req_valid && legacy_core && seg_cross && (tbit_first != tbit_last)
         && (cls == CLS_PLAIN || cls == CLS_BYTEREV || cls == CLS_FPDBL))
        |=> exc_cause == CAUSE_SEGX);
endmodule

// File: tb/align_exc_unit_bench.sv
`timescale 1ns/1ps
module align_exc_unit_bench;
    import align_chk_pkg::*;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        req_valid = 1'b0;
    logic [3:0]  req_class = 4'd0;
    logic [31:0] req_addr = 32'd0;
    logic [2:0]  req_size_lg = 3'd0;
    logic        le_mode = 1'b0;
    logic        legacy_core = 1'b0;
    logic        tbit_first = 1'b0;
    logic        tbit_last = 1'b0;
    logic        out_valid;
    logic        exc_flag;
    logic [2:0]  exc_cause;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    align_exc_unit u_align_exc_unit (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_class(req_class),
        .req_addr(req_addr), .req_size_lg(req_size_lg), .le_mode(le_mode),
        .legacy_core(legacy_core), .tbit_first(tbit_first), .tbit_last(tbit_last),
        .out_valid(out_valid), .exc_flag(exc_flag), .exc_cause(exc_cause)
    );

    task automatic judge(input string tag, input logic exp_v, input logic [2:0] exp_c);
        checks++;
        if (out_valid !== exp_v || exc_cause !== exp_c || exc_flag !== (exp_c != 3'd0)) begin
            errors++;
            $display("FAIL %s: actual valid=%0b flag=%0b cause=%0d expected valid=%0b flag=%0b cause=%0d",
                     tag, out_valid, exc_flag, exc_cause, exp_v, exp_c != 3'd0, exp_c);
        end
    endtask

    task automatic drive(input acc_class_e c, input logic [31:0] a, input logic [2:0] lg,
                         input logic le, input logic leg, input logic t0, input logic t1);
        req_valid = 1'b1; req_class = c; req_addr = a; req_size_lg = lg;
        le_mode = le; legacy_core = leg; tbit_first = t0; tbit_last = t1;
    endtask

    // called at a falling edge; strobe one request, check at the next falling edge
    task automatic access(input string tag, input acc_class_e c, input logic [31:0] a,
                          input logic [2:0] lg, input logic le, input logic leg,
                          input logic t0, input logic t1, input logic [2:0] exp_c);
        drive(c, a, lg, le, leg, t0, t1);
        @(posedge clk); #1 req_valid = 1'b0;
        @(negedge clk);
        judge(tag, 1'b1, exp_c);
    endtask

    task automatic test_reset();
        judge("R12 reset", 1'b0, 3'd0);
    endtask

    task automatic test_reserve();
        access("R1 reserve misaligned enhanced", CLS_RESERVE, 32'h1002, 3'd2, 0, 0, 0, 0, 3'd1);
        access("R1 reserve misaligned legacy",   CLS_RESERVE, 32'h1002, 3'd2, 0, 1, 0, 0, 3'd1);
        access("R1 reserve aligned",             CLS_RESERVE, 32'h1004, 3'd2, 0, 1, 0, 0, 3'd0);
    endtask

    task automatic test_le_string();
        access("R2 string LE legacy",    CLS_STRMULT, 32'h2001, 3'd4, 1, 1, 0, 0, 3'd2);
        access("R2 string LE enhanced",  CLS_STRMULT, 32'h2001, 3'd4, 1, 0, 0, 0, 3'd2);
        access("R2 string BE",           CLS_STRMULT, 32'h2001, 3'd4, 0, 1, 0, 0, 3'd0);
    endtask

    task automatic test_plain();
        access("R3 plain LE misaligned legacy",   CLS_PLAIN, 32'h3003, 3'd2, 1, 1, 0, 0, 3'd0);
        access("R3 plain LE misaligned enhanced", CLS_PLAIN, 32'h3003, 3'd2, 1, 0, 0, 0, 3'd0);
    endtask

    task automatic test_extctl();
        access("R4 extctl legacy",   CLS_EXTCTL, 32'h4000, 3'd2, 0, 1, 0, 0, 3'd3);
        access("R4 extctl enhanced", CLS_EXTCTL, 32'h4000, 3'd2, 0, 0, 0, 0, 3'd0);
    endtask

    task automatic test_segment();
        access("R5 cross tbit differ",  CLS_PLAIN, 32'h1FFF_FFFE, 3'd2, 0, 1, 0, 1, 3'd4);
        access("R5 cross tbit equal",   CLS_PLAIN, 32'h1FFF_FFFE, 3'd2, 0, 1, 1, 1, 3'd0);
        access("R5 cross enhanced",     CLS_PLAIN, 32'h1FFF_FFFE, 3'd2, 0, 0, 0, 1, 3'd0);
        access("R5 no cross tbit diff", CLS_PLAIN, 32'h1FFF_FFF0, 3'd2, 0, 1, 0, 1, 3'd0);
        access("R5 wrap at top",        CLS_PLAIN, 32'hFFFF_FFFE, 3'd2, 0, 1, 1, 0, 3'd4);
    endtask

    task automatic test_fp_and_byterev();
        access("R6 fp double word-aligned", CLS_FPDBL,   32'h5004, 3'd3, 0, 1, 0, 0, 3'd0);
        access("R7 byterev misaligned",     CLS_BYTEREV, 32'h6001, 3'd2, 1, 1, 0, 0, 3'd0);
        access("R7 byterev cross",          CLS_BYTEREV, 32'h3FFF_FFFF, 3'd1, 0, 1, 0, 1, 3'd4);
    endtask

    task automatic test_simd();
        access("R8 simd scalar misaligned", CLS_SIMD_SCL, 32'h7002, 3'd2, 0, 0, 0, 0, 3'd5);
        access("R8 simd scalar aligned",    CLS_SIMD_SCL, 32'h7004, 3'd2, 0, 0, 0, 0, 3'd0);
        access("R8 simd vec half misalign", CLS_SIMD_VEC, 32'h7001, 3'd1, 0, 0, 0, 0, 3'd5);
        access("R9 simd v64 not dword",     CLS_SIMD_V64, 32'h8004, 3'd2, 0, 0, 0, 0, 3'd6);
        access("R9 simd v64 dword aligned", CLS_SIMD_V64, 32'h8008, 3'd2, 0, 0, 0, 0, 3'd0);
    endtask

    task automatic test_priority();
        access("R10 simd natural beats dword", CLS_SIMD_V64, 32'h8002, 3'd2, 0, 0, 0, 0, 3'd5);
        access("R10 string beats segment",     CLS_STRMULT, 32'h2FFF_FFF8, 3'd4, 1, 1, 0, 1, 3'd2);
        access("R10 reserve beats segment",    CLS_RESERVE, 32'h0FFF_FFFE, 3'd2, 0, 1, 0, 1, 3'd1);
    endtask

    task automatic test_timing();
        // idle cycle clears outputs
        @(negedge clk);
        judge("R11 idle clears", 1'b0, 3'd0);
        // back-to-back strobes, each result one cycle later
        drive(CLS_EXTCTL, 32'h4000, 3'd2, 0, 1, 0, 0);
        @(posedge clk); #1 drive(CLS_SIMD_V64, 32'h8004, 3'd2, 0, 0, 0, 0);
        @(negedge clk);
        judge("R11 back-to-back first", 1'b1, 3'd3);
        @(posedge clk); #1 req_valid = 1'b0;
        @(negedge clk);
        judge("R11 back-to-back second", 1'b1, 3'd6);
        @(negedge clk);
        judge("R11 idle after pair", 1'b0, 3'd0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        test_reset();
        rst = 1'b0;
        @(negedge clk);
        test_reserve();
        test_le_string();
        test_plain();
        test_extctl();
        test_segment();
        test_fp_and_byterev();
        test_simd();
        test_priority();
        test_timing();
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual run still going expected finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule